// File: doc/BRIEF.md
# DDR SDRAM Power-Up Command Sequencer

This block owns the start-up phase of a DDR SDRAM interface. From the release of the power-on reset, it keeps the memory's clock enable low and the data, strobe and check-bit pads in high impedance. It then waits out a power-stabilisation delay and a calibration interval made of sixteen equal steps. Both waits are counters sized from the clock frequency. When the calibration interval ends, the block raises `ready` and starts to accept writes from a small register port.

After that, software steps the memory through its initialization one command at a time by writing a 4-bit instruction code. The block places each accepted command on the command pins for exactly one clock. It drives the bank and address lines that the command needs. For the extended-mode-register command, these come from a software-written mode value, with the additive-latency bits and the unused top row bit cleared.

A refresh-interval register controls a refresh request generator. While that register holds zero, no refresh request is raised.

Top module: `ddr_init_seq`

## Requirements
- R1: While `por_n` is low: `ddr_cs_n`, `ddr_ras_n`, `ddr_cas_n` and `ddr_we_n` are 1; `ddr_cke` is 0; `dq_hiz` is 1; `ready`, `busy` and `refresh_req` are 0.
- R2: `ready` rises exactly PWR_US*CLK_MHZ + CAL_US*CLK_MHZ rising clock edges after `por_n` goes high, and stays high after that. The power delay comes first, followed by CAL_STEPS equal calibration steps. Until `ready` rises, `ddr_cke` stays 0 and `dq_hiz` stays 1. `dq_hiz` falls together with `ready`.
- R3: A write to any register (`wr_addr` 0 = instruction in `wr_data[3:0]`, 1 = extended mode value in `wr_data[15:0]`, 2 = refresh interval in `wr_data[7:0]`) while `ready` is 0 is ignored. It issues no command and leaves the register unchanged.
- R4: Instruction 4'b0011 puts a NOP on the pins in the cycle after the accepting edge. The pins are cs_n,ras_n,cas_n,we_n = 0,1,1,1, with bank and address lines at 0.
- R5: Instruction 4'b0010 puts a precharge-all on the pins. The pins are 0,0,1,0, address bit 10 is 1, and all other address and bank bits are 0.
- R6: Instruction 4'b0100 puts an extended-mode-register-set on the pins. The pins are 0,0,0,0 and the bank is 2'b01. The address carries the last accepted mode value, with bit 0 as the DLL control (0 = enable, 1 = disable) and bits 5:3 (additive latency) forced to 0.
- R7: With SMALL_DEV set, address bit 12 is 0 on every command.
- R8: A command lasts one cycle and is always followed by at least one deselect cycle (pins 1,1,1,1, bank and address at 0). `busy` is high exactly during the command cycle, and an instruction write sampled while `busy` is high is ignored.
- R9: Any other instruction code issues no command and leaves `busy` low.
- R10: `ddr_cke` rises in the cycle of the first NOP and then stays high until reset. Earlier commands leave it low.
- R11: The refresh interval resets to 0. While it is 0, `refresh_req` stays low. While it is N > 0, `refresh_req` is a one-cycle pulse every N cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 instruction, 1 mode value, 2 refresh interval |
| wr_data | input | 16 | Register write data |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 2 | Bank address |
| ddr_addr | output | ADDR_W | Address lines |
| ddr_cke | output | 1 | Memory clock enable |
| dq_hiz | output | 1 | High: data, strobe and check-bit pads released to high impedance |
| ready | output | 1 | Start-up waits complete; registers writable |
| busy | output | 1 | Command cycle in progress |
| refresh_req | output | 1 | Refresh request pulse |

## Verification
A phase counter that ends too early or too late shows up as `ready` moving by at least one edge, so the bench measures its rise to the exact edge. A wrong pin or bank/address value is visible on the first negative edge after the accepting clock edge. A stuck issue register shows up one cycle later as a missing deselect or a `busy` that stays high. A refresh counter with a bad compare is seen within one interval, because the pulse count over a fixed window changes.

// File: rtl/ddr_init_pkg.sv
`timescale 1ns/1ps
package ddr_init_pkg;

  localparam int ABUS_W = 16;
  typedef logic [ABUS_W-1:0] abus_t;

  typedef enum logic [3:0] {
    INS_PRE  = 4'b0010,
    INS_NOP  = 4'b0011,
    INS_EMRS = 4'b0100
  } instr_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PIN_DESEL = pins_t'(4'b1111);
  localparam pins_t PIN_NOP   = pins_t'(4'b0111);
  localparam pins_t PIN_PRE   = pins_t'(4'b0010);
  localparam pins_t PIN_MRS   = pins_t'(4'b0000);

  localparam int BIT_AUTO_PRE = 10;
  localparam int BIT_ROW_TOP  = 12;
  localparam int AL_LO        = 3;
  localparam int AL_HI        = 5;

  // wait length in clocks for a duration in microseconds
  function automatic int unsigned us_to_cycles(int unsigned us, int unsigned mhz);
    return us * mhz;
  endfunction

  function automatic logic instr_known(logic [3:0] ins);
    return (ins == INS_PRE) || (ins == INS_NOP) || (ins == INS_EMRS);
  endfunction

  function automatic pins_t instr_pins(logic [3:0] ins);
    case (ins)
      INS_NOP:  return PIN_NOP;
      INS_PRE:  return PIN_PRE;
      INS_EMRS: return PIN_MRS;
      default:  return PIN_DESEL;
    endcase
  endfunction

  // extended mode value as driven: latency field cleared, top row bit cleared on small parts
  function automatic abus_t ext_mode_clean(abus_t raw, bit small_dev);
    abus_t v = raw;
    for (int i = AL_LO; i <= AL_HI; i++) v[i] = 1'b0;
    if (small_dev) v[BIT_ROW_TOP] = 1'b0;
    return v;
  endfunction

  function automatic abus_t instr_addr(logic [3:0] ins, abus_t mode, bit small_dev);
    abus_t v = '0;
    case (ins)
      INS_PRE:  v[BIT_AUTO_PRE] = 1'b1;
      INS_EMRS: v = ext_mode_clean(mode, small_dev);
      default:  v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
`timescale 1ns/1ps
module ddr_init_timer #(
  parameter int unsigned PWR_CYC  = 40000,
  parameter int unsigned STEP_CYC = 425000,
  parameter int unsigned STEPS    = 16
) (
  input  logic clk,
  input  logic por_n,
  output logic pwr_done,
  output logic ready
);
  localparam int unsigned MAXC  = (PWR_CYC > STEP_CYC) ? PWR_CYC : STEP_CYC;
  localparam int          CNT_W = $clog2(MAXC + 1);
  localparam int          STP_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  typedef enum logic [1:0] {PH_PWR, PH_CAL, PH_DONE} phase_e;

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [STP_W-1:0]   step_q;
  logic               cnt_end;
  logic               last_step;

  assign cnt_end   = (phase_q == PH_PWR) ? (cnt_q == CNT_W'(PWR_CYC - 1))
                                         : (cnt_q == CNT_W'(STEP_CYC - 1));
  assign last_step = (step_q == STP_W'(STEPS - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase_q <= PH_PWR;
      cnt_q   <= '0;
      step_q  <= '0;
    end else begin
      case (phase_q)
        PH_PWR: begin
          if (cnt_end) begin
            phase_q <= PH_CAL;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_CAL: begin
          if (cnt_end) begin
            cnt_q <= '0;
            if (last_step) phase_q <= PH_DONE;
            else           step_q  <= step_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_DONE;
      endcase
    end
  end

  assign pwr_done = (phase_q != PH_PWR);
  assign ready    = (phase_q == PH_DONE);

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    ready |=> ready); // R2
  AST_CAL_AFTER_PWR: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ready) |-> $past(pwr_done)); // R2
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!por_n)
    step_q <= STP_W'(STEPS - 1)); // R2

endmodule

// File: rtl/ddr_init_cmd.sv
`timescale 1ns/1ps
module ddr_init_cmd
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter bit SMALL_DEV = 1'b1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ready,
  input  logic              instr_we,
  input  logic [3:0]        instr,
  input  abus_t             mode_val,
  output pins_t             pins,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              cke,
  output logic              busy
);
  pins_t             pins_q;
  logic [1:0]        ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cke_q;
  logic              accept;
  abus_t             next_addr;

  assign busy      = !pins_q.cs_n;
  assign accept    = instr_we && ready && !busy && instr_known(instr);
  assign next_addr = instr_addr(instr, mode_val, SMALL_DEV);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pins_q <= PIN_DESEL;
      ba_q   <= '0;
      addr_q <= '0;
      cke_q  <= 1'b0;
    end else begin
      if (accept) begin
        pins_q <= instr_pins(instr);
        ba_q   <= (instr == INS_EMRS) ? 2'b01 : 2'b00;
        addr_q <= next_addr[ADDR_W-1:0];
        if (instr == INS_NOP) cke_q <= 1'b1;
      end else begin
        pins_q <= PIN_DESEL;
        ba_q   <= '0;
        addr_q <= '0;
      end
    end
  end

  assign pins = pins_q;
  assign ba   = ba_q;
  assign addr = addr_q;
  assign cke  = cke_q;

  AST_DESEL_AFTER_CMD: assert property (@(posedge clk) disable iff (!por_n)
    !pins_q.cs_n |=> pins_q == PIN_DESEL); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    pins_q.cs_n |-> (ba_q == 2'b00) && (addr_q == '0)); // R8
  AST_NO_EARLY_CMD: assert property (@(posedge clk) disable iff (!por_n)
    !ready |=> pins_q.cs_n); // R3
  AST_CKE_EARLY_LOW: assert property (@(posedge clk) disable iff (!por_n)
    !ready |-> !cke_q); // R2
  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    cke_q |=> cke_q); // R10
  AST_CKE_ON_NOP: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cke_q) |-> pins_q == PIN_NOP); // R10
  AST_PRE_FIELDS: assert property (@(posedge clk) disable iff (!por_n)
    (pins_q == PIN_PRE) |-> addr_q[BIT_AUTO_PRE] && (ba_q == 2'b00)); // R5
  AST_EMRS_FIELDS: assert property (@(posedge clk) disable iff (!por_n)
    (pins_q == PIN_MRS) |-> (ba_q == 2'b01) && (addr_q[AL_HI:AL_LO] == '0)); // R6

  generate
    if (SMALL_DEV && ADDR_W > BIT_ROW_TOP) begin : g_top_row
      AST_TOP_ROW_LOW: assert property (@(posedge clk) disable iff (!por_n)
        !pins_q.cs_n |-> !addr_q[BIT_ROW_TOP]); // R7
    end
  endgenerate

endmodule

// File: rtl/ddr_init_refresh.sv
`timescale 1ns/1ps
module ddr_init_refresh #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] rate,
  output logic              req
);
  logic [RATE_W-1:0] cnt_q;
  logic              req_q;
  logic              running;

  assign running = enable && (rate != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (!running) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (cnt_q >= rate - RATE_W'(1)) begin
      cnt_q <= '0;
      req_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      req_q <= 1'b0;
    end
  end

  assign req = req_q;

  AST_REF_OFF: assert property (@(posedge clk) disable iff (!por_n)
    (rate == '0) |=> !req_q); // R11
  AST_REF_GATED: assert property (@(posedge clk) disable iff (!por_n)
    !enable |=> !req_q); // R11
  AST_REF_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    (req_q && rate != RATE_W'(1)) |=> !req_q); // R11

endmodule

// File: rtl/ddr_init_seq.sv
`timescale 1ns/1ps
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 200,
  parameter int unsigned PWR_US    = 200,
  parameter int unsigned CAL_US    = 34000,
  parameter int unsigned CAL_STEPS = 16,
  parameter int          ADDR_W    = 13,
  parameter bit          SMALL_DEV = 1'b1,
  parameter int          RATE_W    = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [15:0]       wr_data,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [1:0]        ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              ddr_cke,
  output logic              dq_hiz,
  output logic              ready,
  output logic              busy,
  output logic              refresh_req
);
  localparam int unsigned PWR_CYC  = us_to_cycles(PWR_US, CLK_MHZ);
  localparam int unsigned STEP_CYC = us_to_cycles(CAL_US, CLK_MHZ) / CAL_STEPS;

  localparam logic [1:0] REG_INSTR = 2'd0;
  localparam logic [1:0] REG_MODE  = 2'd1;
  localparam logic [1:0] REG_RATE  = 2'd2;

  logic              pwr_done;
  logic              ready_w;
  abus_t             mode_q;
  logic [RATE_W-1:0] rate_q;
  logic              reg_wr;
  pins_t             pins_w;

  ddr_init_timer #(
    .PWR_CYC (PWR_CYC),
    .STEP_CYC(STEP_CYC),
    .STEPS   (CAL_STEPS)
  ) u_timer (
    .clk     (clk),
    .por_n   (por_n),
    .pwr_done(pwr_done),
    .ready   (ready_w)
  );

  assign reg_wr = wr_en && ready_w;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q <= '0;
      rate_q <= '0;
    end else if (reg_wr) begin
      if (wr_addr == REG_MODE) mode_q <= wr_data;
      if (wr_addr == REG_RATE) rate_q <= wr_data[RATE_W-1:0];
    end
  end

  ddr_init_cmd #(
    .ADDR_W   (ADDR_W),
    .SMALL_DEV(SMALL_DEV)
  ) u_cmd (
    .clk     (clk),
    .por_n   (por_n),
    .ready   (ready_w),
    .instr_we(wr_en && (wr_addr == REG_INSTR)),
    .instr   (wr_data[3:0]),
    .mode_val(mode_q),
    .pins    (pins_w),
    .ba      (ddr_ba),
    .addr    (ddr_addr),
    .cke     (ddr_cke),
    .busy    (busy)
  );

  ddr_init_refresh #(
    .RATE_W(RATE_W)
  ) u_refresh (
    .clk   (clk),
    .por_n (por_n),
    .enable(ready_w),
    .rate  (rate_q),
    .req   (refresh_req)
  );

  assign ddr_cs_n  = pins_w.cs_n;
  assign ddr_ras_n = pins_w.ras_n;
  assign ddr_cas_n = pins_w.cas_n;
  assign ddr_we_n  = pins_w.we_n;
  assign dq_hiz    = !ready_w;
  assign ready     = ready_w;

  AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    !ready_w |=> (mode_q == '0) && (rate_q == '0)); // R3

endmodule

// File: tb/ddr_init_seq_test.sv
`timescale 1ns/1ps
module ddr_init_seq_test;
  localparam int AW       = 13;
  localparam int MHZ      = 1;
  localparam int P_US     = 200;
  localparam int C_US     = 3200;
  localparam int READY_AT = P_US * MHZ + C_US * MHZ;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          cs_n, ras_n, cas_n, we_n, cke, dq_hiz, ready, busy, refresh_req;
  logic [1:0]    ba;
  logic [AW-1:0] addr;

  int errors = 0;
  int checks = 0;
  int edges  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!por_n) edges <= 0;
    else        edges <= edges + 1;
  end

  ddr_init_seq #(
    .CLK_MHZ(MHZ), .PWR_US(P_US), .CAL_US(C_US), .CAL_STEPS(16),
    .ADDR_W(AW), .SMALL_DEV(1'b1), .RATE_W(8)
  ) uut (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ddr_cs_n(cs_n), .ddr_ras_n(ras_n), .ddr_cas_n(cas_n), .ddr_we_n(we_n),
    .ddr_ba(ba), .ddr_addr(addr), .ddr_cke(cke), .dq_hiz(dq_hiz),
    .ready(ready), .busy(busy), .refresh_req(refresh_req)
  );

  // addr(2) data(16) cmd cs,ras,cas,we(4) ba(2) addr(13) cke(1) busy(1)
  localparam int NV = 12;
  localparam logic [38:0] VEC [NV] = '{
    {2'd0, 16'h0004, 4'b0000, 2'b01, 13'h0000, 1'b0, 1'b1}, // R3 R6: early mode write was dropped
    {2'd1, 16'h0001, 4'b1111, 2'b00, 13'h0000, 1'b0, 1'b0}, // mode write, no command
    {2'd0, 16'h0004, 4'b0000, 2'b01, 13'h0001, 1'b0, 1'b1}, // R6 DLL off
    {2'd1, 16'h1039, 4'b1111, 2'b00, 13'h0000, 1'b0, 1'b0},
    {2'd0, 16'h0004, 4'b0000, 2'b01, 13'h0001, 1'b0, 1'b1}, // R6 R7 latency and top bit cleared
    {2'd1, 16'h0002, 4'b1111, 2'b00, 13'h0000, 1'b0, 1'b0},
    {2'd0, 16'h0004, 4'b0000, 2'b01, 13'h0002, 1'b0, 1'b1}, // R6 DLL on
    {2'd0, 16'h0002, 4'b0010, 2'b00, 13'h0400, 1'b0, 1'b1}, // R5 R10 cke still low
    {2'd0, 16'h0005, 4'b1111, 2'b00, 13'h0000, 1'b0, 1'b0}, // R9
    {2'd0, 16'h0003, 4'b0111, 2'b00, 13'h0000, 1'b1, 1'b1}, // R4 R10
    {2'd0, 16'h0002, 4'b0010, 2'b00, 13'h0400, 1'b1, 1'b1}, // R5 R10 cke held
    {2'd0, 16'h0003, 4'b0111, 2'b00, 13'h0000, 1'b1, 1'b1}  // R4
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at a negedge, sampled at the next posedge, return at the following negedge
  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'b0111: return "R4";
      4'b0010: return "R5";
      4'b0000: return "R6";
      default: return "R9";
    endcase
  endfunction

  initial begin
    int first_ready;
    int pulses;
    bit twin;
    bit prev;
    // reset state (R1)
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1", "pins", {cs_n, ras_n, cas_n, we_n}, 4'hF);
    chk(!cke && dq_hiz && !ready && !busy && !refresh_req, "R1", "cke,hiz,ready,busy,req",
        {cke, dq_hiz, ready, busy, refresh_req}, 5'b01000);
    por_n = 1'b1;

    // power phase over, calibration still running (R2)
    while (edges < P_US * MHZ + 5) @(negedge clk);
    chk(!ready && !cke && dq_hiz, "R2", "ready,cke,hiz in calibration",
        {ready, cke, dq_hiz}, 3'b001);

    // writes during calibration are dropped (R3)
    reg_write(2'd0, 16'h0003);
    chk(cs_n && !cke && !busy, "R3", "cs_n,cke,busy after early NOP", {cs_n, cke, busy}, 3'b100);
    reg_write(2'd1, 16'h0001);
    reg_write(2'd2, 16'h0001);

    while (!ready) @(negedge clk);
    first_ready = edges;
    chk(first_ready == READY_AT, "R2", "edges to ready", first_ready, READY_AT);
    chk(!dq_hiz && !cke, "R2", "hiz,cke at ready", {dq_hiz, cke}, 2'b00);
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (refresh_req) pulses++;
    end
    chk(pulses == 0, "R3", "refresh pulses after early interval write", pulses, 0);

    // command table
    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      reg_write(v[38:37], v[36:21]);
      chk({cs_n, ras_n, cas_n, we_n} == v[20:17], tag_of(v[20:17]), "pins",
          {cs_n, ras_n, cas_n, we_n}, v[20:17]);
      chk(ba == v[16:15] && addr == v[14:2], tag_of(v[20:17]), "bank,addr",
          {ba, addr}, {v[16:15], v[14:2]});
      chk(cke == v[1], "R10", "cke", cke, v[1]);
      chk(busy == v[0], "R8", "busy", busy, v[0]);
      @(negedge clk);
      chk({cs_n, ras_n, cas_n, we_n} == 4'b1111 && !busy && ba == 0 && addr == 0, "R8",
          "deselect after command", {cs_n, ras_n, cas_n, we_n, busy}, 5'b11110);
    end

    // top row bit on its own (R7)
    reg_write(2'd1, 16'h1000);
    reg_write(2'd0, 16'h0004);
    chk(!cs_n && addr == 0 && ba == 2'b01, "R7", "addr with bit 12 requested", addr, 0);
    @(negedge clk);

    // back-to-back instruction while busy is dropped (R8)
    reg_write(2'd0, 16'h0003);
    chk(busy && {cs_n, ras_n, cas_n, we_n} == 4'b0111, "R8", "first of pair",
        {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    reg_write(2'd0, 16'h0002);
    chk(cs_n && !busy, "R8", "write during busy ignored", {cs_n, busy}, 2'b10);
    reg_write(2'd0, 16'h0002);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0010 && addr == 13'h0400, "R5", "precharge after gap",
        {cs_n, ras_n, cas_n, we_n}, 4'b0010);
    @(negedge clk);

    // refresh interval (R11)
    reg_write(2'd2, 16'h0004);
    pulses = 0; twin = 0; prev = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (refresh_req) pulses++;
      if (refresh_req && prev) twin = 1;
      prev = refresh_req;
    end
    chk(pulses == 10, "R11", "pulses over 40 cycles at interval 4", pulses, 10);
    chk(!twin, "R11", "adjacent pulses", twin, 0);
    reg_write(2'd2, 16'h0000);
    @(negedge clk);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (refresh_req) pulses++;
    end
    chk(pulses == 0, "R11", "pulses at interval 0", pulses, 0);
    chk(cke, "R10", "cke held at end", cke, 1);

    // reset again mid-operation (R1)
    por_n = 1'b0;
    @(negedge clk);
    chk(!cke && dq_hiz && !ready && cs_n && !busy, "R1", "state after second reset",
        {cke, dq_hiz, ready, cs_n, busy}, 5'b01010);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule